// File: doc/BRIEF.md
# Signature Chain Unlock Gate

This block guards a feature enable behind a challenge and response exchange over a small 32-bit register port. Software first sets an arm bit in the configuration register. It then reads a seed register, which returns the current value of a free-running generator, and writes zero to a signature register. After that it writes thirteen signatures. Each signature is the previous expected value pushed 257 steps through a masked-parity shift generator. The first expected value is the seed advanced 257 steps.

The block repeats every step on its own generator, one step per clock. It checks each write against its own result. It raises the grant level only when the whole chain has matched. Any wrong step locks the gate until the next reset, and so does any further attempt after the first one. The grant level is hidden in the status register unless a chip-ID select bit is set. Downstream logic takes the grant level straight from an output pin.

Top module: `sig_unlock_gate`

## Requirements
- R1: One generator step shifts the 32-bit value left by one and places in bit 0 the XOR of all bits of the old value ANDed with 0x80080125.
- R2: Reading the seed register (address 1) while the arm bit (configuration bit 0, address 0) is set opens an attempt. The value returned by that read is the chain's starting value.
- R3: The first write to the signature register (address 2) after the seed read must be zero. Any other value fails the attempt.
- R4: Thirteen signature writes follow the zero write. The k-th write must equal the starting value advanced 257·k steps.
- R5: After the zero write and after each accepted signature, `seq_busy` is high for exactly 257 cycles. A signature write while busy fails the attempt.
- R6: After the thirteenth correct signature, `grant_level` takes the value of the GRANT_LEVEL parameter (default 1) from the next cycle on.
- R7: A failed attempt drives `grant_level` to 0. It stays 0 until reset, and a correct chain written later does not grant.
- R8: Opening a second attempt, whether the first one succeeded or failed, revokes any grant and locks the gate until reset.
- R9: Clearing the arm bit while an attempt is open fails the attempt.
- R10: The status register (address 3) returns the level in bits [1:0]: 0 for not enabled, 1 for level one, 2 for level two, 3 for unknown. It returns the level only while the chip-ID select bit (configuration bit 1) is set, and 0 otherwise. The signature register reads as 0.
- R11: A seed read with the arm bit clear, and signature writes with no attempt open, change nothing.
- R12: After reset, the configuration register, `grant_level`, `seq_busy` and the status register are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read |
| grant_level | output | 2 | Enabled level for the guarded feature |
| seq_busy | output | 1 | Generator advancing, signature writes refused |

## Verification
A wrong sequence state or counter shows up as `seq_busy` or `grant_level` differing from the model in the cycle it goes wrong, because both pins are compared on every clock. A chain index that is off by one shows up as a grant one signature too early or too late. A busy window of the wrong length shows up at both of its ends. A lock flag that clears, or an attempt flag that is not kept, only shows when a later attempt grants where the model expects a lock. For that reason the tests follow every failure with a full correct chain.

// File: rtl/unlk_pkg.sv
package unlk_pkg;

    localparam int          WORD_W  = 32;
    localparam int          ADDR_W  = 2;
    localparam logic [31:0] FB_MASK = 32'h8008_0125;

    typedef enum logic [ADDR_W-1:0] {
        RA_CFG  = 2'd0,
        RA_SEED = 2'd1,
        RA_SIG  = 2'd2,
        RA_STAT = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        LV_NONE    = 2'd0,
        LV_ONE     = 2'd1,
        LV_TWO     = 2'd2,
        LV_UNKNOWN = 2'd3
    } level_e;

    typedef enum logic [1:0] {
        SQ_IDLE      = 2'd0,
        SQ_WAIT_ZERO = 2'd1,
        SQ_CHAIN     = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic chip_id_sel;
        logic arm;
    } cfg_t;

    // One generator step: shift left, masked parity into bit 0.
    function automatic logic [WORD_W-1:0] sig_step(input logic [WORD_W-1:0] v);
        return {v[WORD_W-2:0], ^(v & FB_MASK)};
    endfunction

endpackage

// File: rtl/unlk_seed_gen.sv
module unlk_seed_gen
    import unlk_pkg::*;
#(
    parameter bit              USE_LFSR  = 1'b1,
    parameter logic [WORD_W-1:0] SEED_INIT = 32'h0000_0001
) (
    input  logic              clk,
    input  logic              rst,
    output logic [WORD_W-1:0] seed
);

    generate
        if (USE_LFSR) begin : g_lfsr
            localparam logic [WORD_W-1:0] TAPS = 32'h8020_0003;
            always_ff @(posedge clk) begin
                if (rst) seed <= SEED_INIT;
                else     seed <= {1'b0, seed[WORD_W-1:1]} ^ (seed[0] ? TAPS : '0);
            end
            // R2: the seed source never locks up at zero
            a_r2_seed_live: assert property (@(posedge clk) disable iff (rst)
                seed != '0);
        end else begin : g_count
            always_ff @(posedge clk) begin
                if (rst) seed <= SEED_INIT;
                else     seed <= seed + 1'b1;
            end
        end
    endgenerate

endmodule

// File: rtl/unlk_sig_stepper.sv
module unlk_sig_stepper
    import unlk_pkg::*;
#(
    parameter int STEPS = 257
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [WORD_W-1:0] load,
    output logic              busy,
    output logic [WORD_W-1:0] value
);

    localparam int CNT_W = $clog2(STEPS + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt   <= '0;
            value <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            cnt   <= CNT_W'(STEPS);
            value <= load;
        end else if (busy) begin
            value <= sig_step(value);
            cnt   <= cnt - 1'b1;
            if (cnt == CNT_W'(1)) busy <= 1'b0;
        end
    end

    // R5: busy ends only when the step budget is spent
    a_r5_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (busy && !start && cnt != CNT_W'(1)) |=> busy);
    // R5: the result is held once the advance is finished
    a_r5_result_held: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(value));

endmodule

// File: rtl/unlk_seq_ctrl.sv
module unlk_seq_ctrl
    import unlk_pkg::*;
#(
    parameter int CHAIN_LEN = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm,
    input  logic              seed_rd,
    input  logic [WORD_W-1:0] seed_val,
    input  logic              sig_wr,
    input  logic [WORD_W-1:0] sig_data,
    input  logic              step_busy,
    input  logic [WORD_W-1:0] step_value,
    output logic              step_start,
    output logic [WORD_W-1:0] step_load,
    output logic              enabled,
    output logic              dead
);

    localparam int IDX_W = $clog2(CHAIN_LEN + 1);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(CHAIN_LEN - 1);

    seq_state_e        state, state_n;
    logic [IDX_W-1:0]  idx, idx_n;
    logic [WORD_W-1:0] seed_q, seed_n;
    logic              attempted, att_n;
    logic              fail, grant;

    always_comb begin
        state_n    = state;
        idx_n      = idx;
        seed_n     = seed_q;
        att_n      = attempted;
        fail       = 1'b0;
        grant      = 1'b0;
        step_start = 1'b0;
        step_load  = seed_q;
        if (state != SQ_IDLE && !arm) begin
            fail = 1'b1;
        end else if (seed_rd && arm) begin
            if (state != SQ_IDLE || attempted) begin
                fail = 1'b1;
            end else begin
                att_n   = 1'b1;
                seed_n  = seed_val;
                state_n = SQ_WAIT_ZERO;
            end
        end else if (sig_wr) begin
            case (state)
                SQ_WAIT_ZERO: begin
                    if (sig_data == '0) begin
                        step_start = 1'b1;
                        step_load  = seed_q;
                        idx_n      = '0;
                        state_n    = SQ_CHAIN;
                    end else begin
                        fail = 1'b1;
                    end
                end
                SQ_CHAIN: begin
                    if (step_busy || sig_data != step_value) begin
                        fail = 1'b1;
                    end else if (idx == LAST) begin
                        grant   = 1'b1;
                        state_n = SQ_IDLE;
                    end else begin
                        idx_n      = idx + 1'b1;
                        step_start = 1'b1;
                        step_load  = step_value;
                    end
                end
                default: ;
            endcase
        end
        if (fail) state_n = SQ_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SQ_IDLE;
            idx       <= '0;
            seed_q    <= '0;
            attempted <= 1'b0;
            enabled   <= 1'b0;
            dead      <= 1'b0;
        end else begin
            state     <= state_n;
            idx       <= idx_n;
            seed_q    <= seed_n;
            attempted <= att_n;
            dead      <= dead | fail;
            enabled   <= fail ? 1'b0 : (enabled | grant);
        end
    end

    // R7: a lock never lifts before reset
    a_r7_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        dead |=> dead);
    // R7: a locked gate never grants
    a_r7_lock_no_grant: assert property (@(posedge clk) disable iff (rst)
        dead |-> !enabled);
    // R6: a grant appears only at the end of a full chain
    a_r6_grant_after_chain: assert property (@(posedge clk) disable iff (rst)
        $rose(enabled) |-> ($past(state) == SQ_CHAIN && $past(idx) == LAST));
    // R9: dropping the arm bit inside an attempt locks the gate
    a_r9_disarm_fails: assert property (@(posedge clk) disable iff (rst)
        (state != SQ_IDLE && !arm) |=> (state == SQ_IDLE && dead));
    // R5: a new advance never starts over a running one
    a_r5_start_when_free: assert property (@(posedge clk) disable iff (rst)
        step_start |-> !step_busy);

endmodule

// File: rtl/sig_unlock_gate.sv
module sig_unlock_gate
    import unlk_pkg::*;
#(
    parameter int          CHAIN_LEN     = 13,
    parameter int          STEPS         = 257,
    parameter int          GRANT_LEVEL   = 1,
    parameter bit          SEED_USE_LFSR = 1'b1,
    parameter logic [31:0] SEED_INIT     = 32'h0000_0001
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic [1:0]  grant_level,
    output logic        seq_busy
);

    localparam level_e GRANT_CODE = level_e'(GRANT_LEVEL[1:0]);

    cfg_t              cfg;
    reg_addr_e         addr;
    logic              rd_req, wr_req;
    logic [WORD_W-1:0] seed;
    logic              step_start, step_busy;
    logic [WORD_W-1:0] step_load, step_value;
    logic              enabled, dead;
    level_e            level;

    assign addr   = reg_addr_e'(bus_addr);
    assign rd_req = bus_sel && !bus_wr;
    assign wr_req = bus_sel && bus_wr;
    assign level  = enabled ? GRANT_CODE : LV_NONE;

    unlk_seed_gen #(
        .USE_LFSR  (SEED_USE_LFSR),
        .SEED_INIT (SEED_INIT)
    ) u_seed (
        .clk  (clk),
        .rst  (rst),
        .seed (seed)
    );

    unlk_sig_stepper #(
        .STEPS (STEPS)
    ) u_step (
        .clk   (clk),
        .rst   (rst),
        .start (step_start),
        .load  (step_load),
        .busy  (step_busy),
        .value (step_value)
    );

    unlk_seq_ctrl #(
        .CHAIN_LEN (CHAIN_LEN)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .arm        (cfg.arm),
        .seed_rd    (rd_req && addr == RA_SEED),
        .seed_val   (seed),
        .sig_wr     (wr_req && addr == RA_SIG),
        .sig_data   (bus_wdata),
        .step_busy  (step_busy),
        .step_value (step_value),
        .step_start (step_start),
        .step_load  (step_load),
        .enabled    (enabled),
        .dead       (dead)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg       <= '0;
            bus_rdata <= '0;
        end else begin
            if (wr_req && addr == RA_CFG) cfg <= cfg_t'(bus_wdata[1:0]);
            bus_rdata <= '0;
            if (rd_req) begin
                case (addr)
                    RA_CFG:  bus_rdata <= {30'd0, cfg};
                    RA_SEED: bus_rdata <= seed;
                    RA_STAT: bus_rdata <= cfg.chip_id_sel ? {30'd0, level} : '0;
                    default: bus_rdata <= '0;
                endcase
            end
        end
    end

    assign grant_level = level;
    assign seq_busy    = step_busy;

    // R10: status stays hidden without the chip-ID select
    a_r10_status_hidden: assert property (@(posedge clk) disable iff (rst)
        (rd_req && addr == RA_STAT && !cfg.chip_id_sel) |=> bus_rdata == '0);
    // R7: a locked gate drives no level to the feature
    a_r7_pin_locked: assert property (@(posedge clk) disable iff (rst)
        dead |-> grant_level == LV_NONE);

endmodule

// File: tb/sig_unlock_gate_bench.sv
module sig_unlock_gate_bench;

    localparam int STEPS = 257;
    localparam int NSIG  = 13;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  grant_level;
    logic        seq_busy;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;  // 125 MHz

    sig_unlock_gate u_sig_unlock_gate (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .grant_level(grant_level), .seq_busy(seq_busy)
    );

    // R1: behavioural generator
    function automatic logic [31:0] adv(input logic [31:0] v, input int n);
        logic [31:0] x = v;
        for (int i = 0; i < n; i++) begin
            bit p = 0;
            for (int b = 0; b < 32; b++) if (b == 0 || b == 2 || b == 5 || b == 8 || b == 19 || b == 31) p ^= x[b];
            x = {x[30:0], p};
        end
        return x;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference model, advanced once per clock
    int          m_state, m_idx, m_busy;
    bit          m_att, m_dead, m_en, m_fl, m_bb;
    logic [31:0] m_seed, m_exp;
    logic [1:0]  m_cfg;

    always @(posedge clk) begin
        if (rst) begin
            m_state = 0; m_idx = 0; m_busy = 0;
            m_att = 0; m_dead = 0; m_en = 0; m_cfg = 0;
        end else begin
            m_fl = 0;
            m_bb = (m_busy > 0);
            if (m_busy > 0) m_busy--;
            if (m_state != 0 && !m_cfg[0]) m_fl = 1;
            else if (bus_sel && !bus_wr && bus_addr == 2'd1 && m_cfg[0]) begin
                if (m_state != 0 || m_att) m_fl = 1;
                else begin m_att = 1; m_state = 1; end
            end else if (bus_sel && bus_wr && bus_addr == 2'd2) begin
                if (m_state == 1) begin
                    if (bus_wdata == 0) begin
                        m_exp = adv(m_seed, STEPS); m_busy = STEPS; m_state = 2; m_idx = 0;
                    end else m_fl = 1;
                end else if (m_state == 2) begin
                    if (m_bb || bus_wdata != m_exp) m_fl = 1;
                    else if (m_idx == NSIG - 1) begin m_en = 1; m_state = 0; end
                    else begin m_idx++; m_exp = adv(m_exp, STEPS); m_busy = STEPS; end
                end
            end
            if (m_fl) begin m_dead = 1; m_en = 0; m_state = 0; end
            if (bus_sel && bus_wr && bus_addr == 2'd0) m_cfg = bus_wdata[1:0];
        end
    end

    // Pin comparison on every clock: R5 busy window, R6/R7/R8 grant
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R5 seq_busy", {31'd0, seq_busy}, {31'd0, m_busy > 0});
            chk("R6 grant_level", {30'd0, grant_level}, m_en ? 32'd1 : 32'd0);
        end
    end

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(negedge clk);
        bus_sel = 0;
        d = bus_rdata;
    endtask

    // Opens an attempt (R2): arm + chip-ID select, then seed read
    task automatic open_attempt(output logic [31:0] s);
        bus_write(2'd0, 32'd3);
        bus_read(2'd1, s);
        m_seed = s;
    endtask

    // Zero write then n correct signatures; bad_at injects a wrong one
    task automatic send_chain(input logic [31:0] s, input int n, input int bad_at);
        logic [31:0] v = s;
        bus_write(2'd2, 32'd0);
        for (int i = 0; i < n; i++) begin
            repeat (260) @(negedge clk);
            v = adv(v, STEPS);
            bus_write(2'd2, (i == bad_at) ? (v ^ 32'h10) : v);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] rd, s;
        do_reset();
        // R12 reset state
        bus_read(2'd0, rd); chk("R12 cfg after reset", rd, 32'd0);
        bus_read(2'd3, rd); chk("R12 status after reset", rd, 32'd0);
        chk("R12 grant after reset", {30'd0, grant_level}, 32'd0);

        // R11 seed read unarmed and idle signature writes are ignored
        bus_read(2'd1, rd);
        bus_write(2'd2, 32'h1234_5678);
        bus_read(2'd2, rd); chk("R10 signature reads zero", rd, 32'd0);
        bus_write(2'd0, 32'd2);
        bus_read(2'd3, rd); chk("R11 status still not enabled", rd, 32'd0);

        // R2 R3 R4 R6 full correct chain
        open_attempt(s);
        send_chain(s, NSIG, -1);
        @(negedge clk);
        chk("R6 grant after chain", {30'd0, grant_level}, 32'd1);
        bus_read(2'd3, rd); chk("R10 status level one", rd, 32'd1);
        bus_write(2'd0, 32'd1);
        bus_read(2'd3, rd); chk("R10 status hidden", rd, 32'd0);

        // R8 second attempt after success revokes and locks
        bus_write(2'd0, 32'd3);
        bus_read(2'd1, rd);
        @(negedge clk);
        chk("R8 grant revoked", {30'd0, grant_level}, 32'd0);
        bus_read(2'd3, rd); chk("R8 status locked", rd, 32'd0);

        // R3 nonzero first write, then R7 a correct retry cannot grant
        do_reset();
        open_attempt(s);
        bus_write(2'd2, 32'd5);
        open_attempt(s);
        send_chain(s, NSIG, -1);
        @(negedge clk);
        chk("R7 no grant after failure", {30'd0, grant_level}, 32'd0);

        // R7 wrong signature in the middle of the chain
        do_reset();
        open_attempt(s);
        send_chain(s, NSIG, 5);
        @(negedge clk);
        chk("R7 wrong signature locks", {30'd0, grant_level}, 32'd0);

        // R5 write while busy fails
        do_reset();
        open_attempt(s);
        bus_write(2'd2, 32'd0);
        repeat (100) @(negedge clk);
        chk("R5 busy during advance", {31'd0, seq_busy}, 32'd1);
        bus_write(2'd2, adv(s, STEPS));
        repeat (300) @(negedge clk);
        chk("R5 busy write locked", {30'd0, grant_level}, 32'd0);

        // R9 arm cleared mid-chain
        do_reset();
        open_attempt(s);
        send_chain(s, 4, -1);
        bus_write(2'd0, 32'd2);
        bus_write(2'd0, 32'd3);
        open_attempt(s);
        send_chain(s, NSIG, -1);
        @(negedge clk);
        chk("R9 disarm locks", {30'd0, grant_level}, 32'd0);

        // R4 a clean chain after reset grants again
        do_reset();
        open_attempt(s);
        send_chain(s, NSIG, -1);
        @(negedge clk);
        chk("R4 chain after reset grants", {30'd0, grant_level}, 32'd1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule